// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block sits on the host side of a parallel NOR flash. Once the host has issued a program or erase command sequence, it pulses `start` together with a polling address, a polling method and the expected value of data bit 7. The block then reads the flash at that address and interprets the status bits until it can decide the outcome. It reports the result as pass, fail or timeout. The reads go through a simple request/response port toward a flash bus adapter. Only one read is outstanding at a time.

Two methods are available. With the expected-data method, the block compares bit 7 of each returned byte with the expected bit 7. With the toggle method, it reads in pairs and watches whether bit 6 still alternates between consecutive reads. In both methods, bit 5 of a status byte flags an exceeded internal time limit. Bit 7 or bit 6 can settle in the same cycle that bit 5 rises, so the block always makes confirming reads before it declares a failure. When a failure is confirmed, the block writes the reset command byte F0h to the polling address. This returns the flash to array read mode.

For a program operation, the polling address is the programmed byte and the expected bit is bit 7 of the programmed data. For an erase, the address is any location inside a sector being erased and the expected bit is 1, because erased data reads FFh. A host-set read budget ends the poll with a timeout if the bus never resolves.

Top module: `flash_done_poller`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `op_pass`, `op_fail`, `op_timeout`, `rd_req` and `wr_req` are all 0.
- R2: Each read raises `rd_req` with `rd_addr` equal to the polling address latched at start. Both are held until `rd_valid` is sampled high, and the byte is taken from `rd_data` in that cycle. A new read is never requested while one is outstanding, and no read is outstanding when `done` pulses.
- R3: Expected-data method (`method` = 0): if bit 7 of a returned byte equals `expect_msb`, the poll ends with pass.
- R4: Expected-data method: if bit 7 differs and bit 5 is 0, another read is made.
- R5: Expected-data method: if bit 7 differs and bit 5 is 1, exactly one more read is made. The poll passes if bit 7 of that byte matches, and fails otherwise.
- R6: Toggle method (`method` = 1): reads come in pairs. If bit 6 is equal in both reads of a pair, the poll passes. If it differs and bit 5 of the second read is 0, a new pair is read.
- R7: Toggle method: if bit 6 differs within a pair and bit 5 of the second read is 1, two more reads are made. The poll passes if bit 6 is equal in those two reads, and fails otherwise.
- R8: On a fail outcome with `FAIL_RESET` = 1, `wr_req` pulses for one cycle in the same cycle as `done`, with `wr_data` = F0h and `wr_addr` = the polling address. A pass or timeout outcome produces no write.
- R9: When the number of completed reads has reached `max_polls` and the rules above still call for another read, the poll ends with timeout. At least one read is always made, and a decisive byte wins over the budget.
- R10: `done` is a one-cycle pulse. In that cycle exactly one of `op_pass`, `op_fail` and `op_timeout` is set, and it stays set until the next accepted start. `busy` is high from the cycle after start until `done`. `last_status` holds the byte of the most recent read.
- R11: A `start` pulse while `busy` is high is ignored. The running poll keeps its address, method and outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a poll (taken only when idle) |
| method | input | 1 | 0 = expected-data method, 1 = toggle method |
| poll_addr | input | AW | Address to poll |
| expect_msb | input | 1 | Expected value of data bit 7 |
| max_polls | input | CW | Read budget |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| op_pass | output | 1 | Outcome: operation completed |
| op_fail | output | 1 | Outcome: operation failed |
| op_timeout | output | 1 | Outcome: read budget exhausted |
| last_status | output | 8 | Byte returned by the latest read |
| rd_req | output | 1 | Read request, held until accepted |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 8 | Read response byte |
| wr_req | output | 1 | Reset-command write strobe |
| wr_addr | output | AW | Write address |
| wr_data | output | 8 | Write data (F0h) |

## Verification
The central corner case is a byte with bit 5 set whose follow-up read has already settled. A design that skips the confirming read would report a false failure, and a design that makes only one confirming read in toggle mode would compare the wrong bytes. Budget edges are aimed at next: a budget of zero, a budget reached in the middle of a toggle pair, and a matching byte on the last allowed read. An off-by-one there shows up as an extra or a missing read, or as a timeout that hides a real pass. A reference model in the bench replays generated status streams in both methods, with several response latencies. It compares the outcome, the read count, the reset write and the final byte. A start pulse is also injected mid-poll, which catches a design that re-latches the address or the method.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int DQ_POLL   = 7;
  localparam int DQ_TOGGLE = 6;
  localparam int DQ_LIMIT  = 5;
  localparam logic [7:0] RESET_CMD = 8'hF0;

  typedef enum logic [2:0] {
    S_IDLE, S_DP_MAIN, S_DP_RECHECK, S_TG_FIRST, S_TG_SECOND, S_TG_RE1, S_TG_RE2
  } state_t;

  typedef enum logic [2:0] {
    A_WAIT, A_READ, A_PASS, A_FAIL, A_TMO
  } act_t;
endpackage

// File: rtl/fdp_read_port.sv
module fdp_read_port #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [AW-1:0] addr_in,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic          accept,
  output logic          resp_pulse,
  output logic [7:0]    resp_byte
);
  assign accept = rd_req & rd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      resp_pulse <= 1'b0;
      resp_byte  <= 8'h00;
    end else begin
      resp_pulse <= 1'b0;
      if (accept) begin
        rd_req     <= 1'b0;
        resp_byte  <= rd_data;
        resp_pulse <= 1'b1;
      end else if (issue && !rd_req) begin
        rd_req  <= 1'b1;
        rd_addr <= addr_in;
      end
    end
  end

  p_req_held_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
  p_req_drops_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_valid |=> !rd_req);
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    issue |-> !rd_req);
endmodule

// File: rtl/fdp_poll_budget.sv
module fdp_poll_budget #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          exhausted
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (tick && count != CNT_MAX) count <= count + 1'b1;
  end

  assign exhausted = (count >= limit);

  p_count_monotonic_r9: assert property (@(posedge clk) disable iff (rst)
    !clear |=> count >= $past(count));
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fdp_pkg::*;
#(
  parameter int AW         = 19,
  parameter int CW         = 16,
  parameter bit FAIL_RESET = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          method,
  input  logic [AW-1:0] poll_addr,
  input  logic          expect_msb,
  input  logic [CW-1:0] max_polls,
  output logic          busy,
  output logic          done,
  output logic          op_pass,
  output logic          op_fail,
  output logic          op_timeout,
  output logic [7:0]    last_status,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  state_t        state, nstate;
  act_t          act;
  logic [AW-1:0] addr_q;
  logic          exp_q, prev_q;
  logic [CW-1:0] lim_q;
  logic          issue, clear, accept, resp_pulse, exhausted;
  logic [7:0]    resp_byte;
  logic          match, toggled, limit_hit;

  fdp_read_port #(.AW(AW)) u_port (
    .clk(clk), .rst(rst), .issue(issue), .addr_in(addr_q),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .accept(accept), .resp_pulse(resp_pulse), .resp_byte(resp_byte)
  );

  fdp_poll_budget #(.CW(CW)) u_budget (
    .clk(clk), .rst(rst), .clear(clear), .tick(accept),
    .limit(lim_q), .exhausted(exhausted)
  );

  assign match     = (resp_byte[DQ_POLL] == exp_q);
  assign toggled   = (resp_byte[DQ_TOGGLE] != prev_q);
  assign limit_hit = resp_byte[DQ_LIMIT];

  always_comb begin
    act    = A_WAIT;
    nstate = state;
    case (state)
      S_IDLE: if (start) begin
        act    = A_READ;
        nstate = method ? S_TG_FIRST : S_DP_MAIN;
      end
      S_DP_MAIN: if (resp_pulse) begin
        if (match)          act = A_PASS;
        else if (exhausted) act = A_TMO;
        else begin
          act    = A_READ;
          nstate = limit_hit ? S_DP_RECHECK : S_DP_MAIN;
        end
      end
      S_DP_RECHECK: if (resp_pulse) act = match ? A_PASS : A_FAIL;
      S_TG_FIRST: if (resp_pulse) begin
        if (exhausted) act = A_TMO;
        else begin act = A_READ; nstate = S_TG_SECOND; end
      end
      S_TG_SECOND: if (resp_pulse) begin
        if (!toggled)       act = A_PASS;
        else if (exhausted) act = A_TMO;
        else begin
          act    = A_READ;
          nstate = limit_hit ? S_TG_RE1 : S_TG_FIRST;
        end
      end
      S_TG_RE1: if (resp_pulse) begin
        if (exhausted) act = A_TMO;
        else begin act = A_READ; nstate = S_TG_RE2; end
      end
      S_TG_RE2: if (resp_pulse) act = toggled ? A_FAIL : A_PASS;
      default: nstate = S_IDLE;
    endcase
    if (act == A_PASS || act == A_FAIL || act == A_TMO) nstate = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      op_pass     <= 1'b0;
      op_fail     <= 1'b0;
      op_timeout  <= 1'b0;
      last_status <= 8'h00;
      wr_req      <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= 8'h00;
      issue       <= 1'b0;
      clear       <= 1'b0;
      addr_q      <= '0;
      exp_q       <= 1'b0;
      prev_q      <= 1'b0;
      lim_q       <= '0;
    end else begin
      state  <= nstate;
      done   <= 1'b0;
      wr_req <= 1'b0;
      clear  <= 1'b0;
      issue  <= (act == A_READ);
      if (state == S_IDLE && start) begin
        addr_q     <= poll_addr;
        exp_q      <= expect_msb;
        lim_q      <= max_polls;
        busy       <= 1'b1;
        op_pass    <= 1'b0;
        op_fail    <= 1'b0;
        op_timeout <= 1'b0;
        clear      <= 1'b1;
      end
      if (resp_pulse) begin
        prev_q      <= resp_byte[DQ_TOGGLE];
        last_status <= resp_byte;
      end
      case (act)
        A_PASS: begin done <= 1'b1; busy <= 1'b0; op_pass <= 1'b1; end
        A_TMO:  begin done <= 1'b1; busy <= 1'b0; op_timeout <= 1'b1; end
        A_FAIL: begin
          done    <= 1'b1;
          busy    <= 1'b0;
          op_fail <= 1'b1;
          wr_req  <= FAIL_RESET;
          wr_addr <= addr_q;
          wr_data <= RESET_CMD;
        end
        default: ;
      endcase
    end
  end

  p_done_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({op_pass, op_fail, op_timeout}));
  p_busy_ends_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_idle_bus_at_done_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_req);
  p_write_on_fail_r8: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> op_fail && done);
  p_timeout_spent_r9: assert property (@(posedge clk) disable iff (rst)
    done && op_timeout |-> exhausted);
  p_addr_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> $stable(addr_q));
  p_recheck_final_r5: assert property (@(posedge clk) disable iff (rst)
    state == S_DP_RECHECK && resp_pulse |=> done && !op_timeout);
endmodule

// File: tb/flash_done_poller_test.sv
module flash_done_poller_test;
  localparam int AW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          method = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic          expect_msb = 1'b0;
  logic [CW-1:0] max_polls = '0;
  logic          busy, done, op_pass, op_fail, op_timeout;
  logic [7:0]    last_status;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid = 1'b0;
  logic [7:0]    rd_data = 8'h00;
  logic          wr_req;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  int errors = 0;
  int checks = 0;

  logic [7:0]    scr [16];
  int            rcount = 0;
  int            lat = 0;
  logic [AW-1:0] cur_addr = '0;
  logic          addr_bad = 1'b0;
  int            wr_count = 0;
  logic [7:0]    wr_seen_data = 8'h00;
  logic [AW-1:0] wr_seen_addr = '0;

  flash_done_poller #(.AW(AW), .CW(CW), .FAIL_RESET(1'b1)) uut (
    .clk(clk), .rst(rst), .start(start), .method(method), .poll_addr(poll_addr),
    .expect_msb(expect_msb), .max_polls(max_polls), .busy(busy), .done(done),
    .op_pass(op_pass), .op_fail(op_fail), .op_timeout(op_timeout),
    .last_status(last_status), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // flash-side responder: answers each request after lat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req && !rd_valid) begin
        repeat (lat) @(negedge clk);
        if (rd_addr != cur_addr) addr_bad = 1'b1;
        rd_data  = (rcount < 16) ? scr[rcount] : 8'h00;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        rcount++;
      end
    end
  end

  always @(posedge clk) begin
    if (wr_req) begin
      wr_count     <= wr_count + 1;
      wr_seen_data <= wr_data;
      wr_seen_addr <= wr_addr;
    end
  end

  // reference from the requirements: res 0 pass, 1 fail, 2 timeout
  function automatic void model(input bit m, input bit ex, input int lim,
                                output int nr, output int res);
    int i;
    logic [7:0] a, b;
    bit fin;
    i = 0; res = 0; fin = 0;
    while (!fin) begin
      if (!m) begin
        a = scr[i]; i++;
        if (a[7] == ex) begin res = 0; fin = 1; end
        else if (i >= lim) begin res = 2; fin = 1; end
        else if (a[5]) begin
          b = scr[i]; i++;
          res = (b[7] == ex) ? 0 : 1; fin = 1;
        end
      end else begin
        a = scr[i]; i++;
        if (i >= lim) begin res = 2; fin = 1; end
        else begin
          b = scr[i]; i++;
          if (a[6] == b[6]) begin res = 0; fin = 1; end
          else if (i >= lim) begin res = 2; fin = 1; end
          else if (b[5]) begin
            a = scr[i]; i++;
            if (i >= lim) begin res = 2; fin = 1; end
            else begin
              b = scr[i]; i++;
              res = (a[6] == b[6]) ? 0 : 1; fin = 1;
            end
          end
        end
      end
    end
    nr = i;
  endfunction

  task automatic load(input logic [7:0] v0, v1, v2, v3, v4, v5);
    for (int k = 0; k < 16; k++) scr[k] = 8'h00;
    scr[0] = v0; scr[1] = v1; scr[2] = v2; scr[3] = v3; scr[4] = v4; scr[5] = v5;
  endtask

  task automatic run(input string tag, input bit m, input bit ex, input int lim,
                     input logic [AW-1:0] addr, input int latency, input bit poke);
    int nr, res, got, waited;
    model(m, ex, lim, nr, res);
    @(negedge clk);
    rcount = 0; wr_count = 0; addr_bad = 1'b0; cur_addr = addr; lat = latency;
    method = m; expect_msb = ex; max_polls = CW'(lim); poll_addr = addr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R10 busy after start"}, int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      method = ~m; poll_addr = ~addr; expect_msb = ~ex; max_polls = '1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11 start ignored, still busy", int'(busy), 1);
    end
    waited = 0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " R10 done seen"}, int'(done), 1);
    got = op_pass ? 0 : (op_fail ? 1 : (op_timeout ? 2 : 3));
    chk({tag, " outcome"}, got, res);
    chk({tag, " R2 read count"}, rcount, nr);
    chk({tag, " R10 last byte"}, int'(last_status), int'(scr[nr-1]));
    @(negedge clk);
    chk({tag, " R10 done is one cycle"}, int'(done), 0);
    chk({tag, " R10 outcome held"}, op_pass ? 0 : (op_fail ? 1 : (op_timeout ? 2 : 3)), res);
    chk({tag, " R2 address"}, int'(addr_bad), 0);
    chk({tag, " R8 write count"}, wr_count, (res == 1) ? 1 : 0);
    if (res == 1) begin
      chk({tag, " R8 write data"}, int'(wr_seen_data), 8'hF0);
      chk({tag, " R8 write addr"}, int'(wr_seen_addr), int'(addr));
    end
    repeat (4) @(negedge clk);
    chk({tag, " R2 no stray reads"}, rcount, nr);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (completion)");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] x;
    for (int k = 0; k < 16; k++) scr[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 outcome flags", int'({op_pass, op_fail, op_timeout}), 0);
    chk("R1 rd_req", int'(rd_req), 0);
    chk("R1 wr_req", int'(wr_req), 0);

    load(8'h80, 0, 0, 0, 0, 0); run("R3 erase FFh poll", 0, 1, 8, 8'h31, 0, 0);
    load(8'h5A, 0, 0, 0, 0, 0); run("R3 program match", 0, 0, 8, 8'h12, 2, 0);
    load(8'h00, 8'h40, 8'h80, 0, 0, 0); run("R4 in progress twice", 0, 1, 8, 8'h44, 1, 0);
    load(8'h20, 8'hA0, 0, 0, 0, 0); run("R5 recheck passes", 0, 1, 8, 8'h55, 0, 0);
    load(8'h00, 8'h20, 8'h20, 0, 0, 0); run("R5 recheck fails", 0, 1, 8, 8'h66, 3, 0);
    load(8'h40, 8'h40, 0, 0, 0, 0); run("R6 no toggle", 1, 0, 8, 8'h07, 0, 0);
    load(8'h40, 8'h00, 8'h40, 8'h40, 0, 0); run("R6 second pair", 1, 0, 8, 8'h08, 1, 0);
    load(8'h00, 8'h60, 8'h20, 8'h20, 0, 0); run("R7 recheck stops", 1, 0, 8, 8'h09, 2, 0);
    load(8'h40, 8'h20, 8'h60, 8'h20, 0, 0); run("R7 still toggling", 1, 0, 8, 8'hA5, 0, 0);
    load(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00); run("R9 budget 3", 0, 1, 3, 8'h0B, 1, 0);
    load(8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00); run("R9 budget mid pair", 1, 0, 5, 8'h0C, 0, 0);
    load(8'h00, 8'h00, 0, 0, 0, 0); run("R9 budget zero", 0, 1, 0, 8'h0D, 0, 0);
    load(8'h00, 8'h00, 8'h80, 0, 0, 0); run("R9 match on last read", 0, 1, 3, 8'h0E, 0, 0);
    load(8'h00, 8'h00, 8'h80, 0, 0, 0); run("R11 mid-poll start", 0, 1, 8, 8'h3C, 4, 1);

    x = 32'h1234_5678;
    for (int s = 0; s < 48; s++) begin
      for (int k = 0; k < 16; k++) begin
        x = x * 32'd1103515245 + 32'd12345;
        scr[k] = x[23:16];
      end
      run("R3 R4 R5 R6 R7 R9 sweep", s[0], x[9], 1 + (s % 7), 8'(s * 5 + 1), s % 3, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule